// File: doc/BRIEF.md
# Ping-Pong Frame Buffer for a Cell Array

This block is a two-set data store between a memory-transfer port and an eight-by-eight array of processing cells. Each set holds 128 words of 64 bits, split across two banks: even word addresses go to one bank and odd ones to the other. At any moment one set faces the array and the other faces the memory side. The memory side fills or drains its set while the array consumes the other one. A swap request exchanges the two roles, so the array never stalls on a transfer.

The array side is fed by a load sequencer. A start pulse with a byte address launches eight beats. Each beat puts 128 bits on the array bus, which is two byte operands for each of the eight cells in a column, and marks the column the beat is for. Each beat is read 16 bytes past the previous one. A byte barrel shifter on the read path lets the first beat begin at any byte, aligned or not.

Top module: `pingpong_frame_buf`

## Requirements
- R1: During reset and at its release, `arr_valid`, `ld_done`, `array_set` and `mem_rdata` are all zero.
- R2: A memory-side write stores `mem_wdata` at word `mem_addr` of the set that is not facing the array, including while a load runs. A memory-side read returns that word of the same set on `mem_rdata` one clock after the address is presented.
- R3: A `swap_req` sampled while no load is running flips `array_set` at that same clock edge.
- R4: A `swap_req` sampled while a load runs is held. `array_set` stays fixed for every beat of the load and flips on the edge where `ld_done` goes high.
- R5: A `ld_start` sampled while idle produces exactly eight consecutive `arr_valid` cycles, starting one clock later, with `arr_col` counting 0 to 7.
- R6: Beat k carries the 16 bytes beginning at byte address `ld_base + 16*k` of the array-facing set. Byte i of the beat sits in bits [8i+7:8i]. Byte address a means byte a mod 8 (bits [8j+7:8j] for j = a mod 8) of word a/8. Any byte alignment of `ld_base` is allowed.
- R7: Byte addresses wrap modulo 1024 within the set, so a beat that runs past byte 1023 continues at byte 0.
- R8: `ld_done` is a one-cycle pulse in the clock right after the beat with `arr_col` = 7.
- R9: A `ld_start` sampled while a load runs is ignored and adds no beats.
- R10: When `swap_req` and `ld_start` are sampled together while idle, the swap happens first, and the load reads from the newly facing set.
- R11: Several swap requests during one load produce a single flip of `array_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_req | input | 1 | Request to exchange the array-facing and memory-facing sets |
| mem_addr | input | 7 | Word address within the memory-facing set |
| mem_we | input | 1 | Write strobe for the memory side |
| mem_wdata | input | 64 | Write data from the memory side |
| mem_rdata | output | 64 | Read data to the memory side, one clock after the address |
| ld_start | input | 1 | Pulse that starts an eight-beat array load |
| ld_base | input | 10 | Byte address of the first beat |
| arr_valid | output | 1 | Array bus carries a beat |
| arr_col | output | 3 | Column of cells that latches the current beat |
| arr_data | output | 128 | Array bus, two bytes per cell of the column |
| ld_done | output | 1 | Pulse one clock after the final beat |
| array_set | output | 1 | Index of the set facing the array |

## Verification
The assertions check the sequencing on every cycle. Columns advance by one within a load and begin at zero. The done pulse lasts exactly one cycle and follows the last column. The facing set stays frozen between beats. An idle swap always flips the set. Only the bench scenarios can show data correctness: the unaligned and wrapping byte windows, memory writes landing in the hidden set while a load runs, deferred and merged swaps, a start ignored while busy, and swap-with-start ordering. The bench checks these against a byte-level model of both sets.

// File: rtl/fb_pkg.sv
package fb_pkg;
    // Default geometry of one set: two banks of FB_ROWS words each.
    localparam int unsigned FB_WORD_W = 64;
    localparam int unsigned FB_ROWS   = 64;
    // Beats per array load (one per column of cells).
    localparam int unsigned FB_BEATS  = 8;
endpackage

// File: rtl/fb_bank.sv
// One storage bank: a write port, a pair of adjacent-row reads for the
// array path and one read for the memory side.
module fb_bank #(
    parameter int unsigned W    = 64,
    parameter int unsigned ROWS = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(ROWS)-1:0]  waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(ROWS)-1:0]  arow,
    output logic [W-1:0]             a_lo,
    output logic [W-1:0]             a_hi,
    input  logic [$clog2(ROWS)-1:0]  mrow,
    output logic [W-1:0]             m_out
);
    localparam int unsigned RW = $clog2(ROWS);

    logic [W-1:0]  cells [ROWS];
    logic [RW-1:0] arow_nx;

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign arow_nx = arow + 1'b1;   // wraps: ROWS is a power of two
    assign a_lo    = cells[arow];
    assign a_hi    = cells[arow_nx];
    assign m_out   = cells[mrow];
endmodule

// File: rtl/fb_byte_shift.sv
// Logarithmic right shifter in byte steps; keeps the low OUT_BYTES bytes.
module fb_byte_shift #(
    parameter int unsigned IN_BYTES  = 24,
    parameter int unsigned OUT_BYTES = 16,
    parameter int unsigned SH_W      = 3
) (
    input  logic [IN_BYTES*8-1:0]  win,
    input  logic [SH_W-1:0]        ofs,
    output logic [OUT_BYTES*8-1:0] out
);
    logic [IN_BYTES*8-1:0] stage [SH_W+1];

    assign stage[0] = win;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        assign stage[s+1] = ofs[s] ? (stage[s] >> (8 * (1 << s))) : stage[s];
    end

    assign out = stage[SH_W][OUT_BYTES*8-1:0];
endmodule

// File: rtl/pingpong_frame_buf.sv
module pingpong_frame_buf #(
    parameter int unsigned WORD_W = fb_pkg::FB_WORD_W,
    parameter int unsigned ROWS   = fb_pkg::FB_ROWS,
    parameter int unsigned BEATS  = fb_pkg::FB_BEATS
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             swap_req,
    input  logic [$clog2(ROWS):0]                            mem_addr,
    input  logic                                             mem_we,
    input  logic [WORD_W-1:0]                                mem_wdata,
    output logic [WORD_W-1:0]                                mem_rdata,
    input  logic                                             ld_start,
    input  logic [$clog2(ROWS)+$clog2(WORD_W/8):0]           ld_base,
    output logic                                             arr_valid,
    output logic [$clog2(BEATS)-1:0]                         arr_col,
    output logic [2*WORD_W-1:0]                              arr_data,
    output logic                                             ld_done,
    output logic                                             array_set
);
    localparam int unsigned BYTES   = WORD_W / 8;
    localparam int unsigned OFS_W   = $clog2(BYTES);
    localparam int unsigned ROW_W   = $clog2(ROWS);
    localparam int unsigned WADDR_W = ROW_W + 1;
    localparam int unsigned BADDR_W = WADDR_W + OFS_W;
    localparam int unsigned BUS_W   = 2 * WORD_W;
    localparam int unsigned COL_W   = $clog2(BEATS);
    localparam int unsigned STRIDE  = BUS_W / 8;
    localparam int unsigned NBANK   = 4;

    typedef struct packed {
        logic               busy;
        logic [COL_W-1:0]   beat;
        logic [BADDR_W-1:0] addr;
        logic               sel;
        logic               pend;
        logic               ov;
        logic [COL_W-1:0]   ocol;
        logic [BUS_W-1:0]   odata;
        logic               done;
        logic [WORD_W-1:0]  mrd;
    } st_t;

    st_t st_d, st_q;

    logic [WORD_W-1:0]   a_lo  [NBANK];
    logic [WORD_W-1:0]   a_hi  [NBANK];
    logic [WORD_W-1:0]   m_out [NBANK];
    logic [ROW_W-1:0]    arow;
    logic [1:0]          i_even, i_odd, i_mem;
    logic [3*WORD_W-1:0] win;
    logic [BUS_W-1:0]    shifted;

    // Banks 0/1 form set 0, banks 2/3 form set 1; low bank holds even words.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_we;
        assign bank_we = mem_we && (st_q.sel != 1'(b / 2))
                                && (mem_addr[0] == 1'(b % 2));
        fb_bank #(.W(WORD_W), .ROWS(ROWS)) u_bank (
            .clk   (clk),
            .we    (bank_we),
            .waddr (mem_addr[WADDR_W-1:1]),
            .wdata (mem_wdata),
            .arow  (arow),
            .a_lo  (a_lo[b]),
            .a_hi  (a_hi[b]),
            .mrow  (mem_addr[WADDR_W-1:1]),
            .m_out (m_out[b])
        );
    end

    // Three consecutive words cover any unaligned 16-byte window.
    assign arow   = st_q.addr[BADDR_W-1:OFS_W+1];
    assign i_even = {st_q.sel, 1'b0};
    assign i_odd  = {st_q.sel, 1'b1};
    assign i_mem  = {~st_q.sel, mem_addr[0]};
    assign win    = st_q.addr[OFS_W]
                  ? {a_hi[i_odd],  a_hi[i_even], a_lo[i_odd]}
                  : {a_hi[i_even], a_lo[i_odd],  a_lo[i_even]};

    fb_byte_shift #(.IN_BYTES(3 * BYTES), .OUT_BYTES(2 * BYTES), .SH_W(OFS_W)) u_shift (
        .win (win),
        .ofs (st_q.addr[OFS_W-1:0]),
        .out (shifted)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ov   = 1'b0;
        st_d.mrd  = m_out[i_mem];
        st_d.done = st_q.ov && (st_q.ocol == COL_W'(BEATS - 1));

        if (st_q.busy) begin
            st_d.ov    = 1'b1;
            st_d.ocol  = st_q.beat;
            st_d.odata = shifted;
            st_d.addr  = st_q.addr + BADDR_W'(STRIDE);
            st_d.beat  = st_q.beat + 1'b1;
            if (st_q.beat == COL_W'(BEATS - 1)) begin
                st_d.busy = 1'b0;
            end
        end

        // Swap: held while a load runs, applied once the sequencer is idle.
        if (st_q.busy) begin
            if (swap_req) begin
                st_d.pend = 1'b1;
            end
        end else if (swap_req || st_q.pend) begin
            st_d.sel  = ~st_q.sel;
            st_d.pend = 1'b0;
        end

        if (!st_q.busy && ld_start) begin
            st_d.busy = 1'b1;
            st_d.beat = '0;
            st_d.addr = ld_base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_rdata = st_q.mrd;
    assign arr_valid = st_q.ov;
    assign arr_col   = st_q.ocol;
    assign arr_data  = st_q.odata;
    assign ld_done   = st_q.done;
    assign array_set = st_q.sel;
endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
    parameter int unsigned COL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             swap_req,
    input logic             busy,
    input logic             arr_valid,
    input logic [COL_W-1:0] arr_col,
    input logic             ld_done,
    input logic             array_set
);
    localparam logic [COL_W-1:0] LAST = '1;

    // R5: columns advance by one inside a load
    a_r5_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_col != LAST) |=> (arr_valid && arr_col == $past(arr_col) + 1'b1));

    // R5: a load opens on column zero
    a_r5_first_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_valid) |-> (arr_col == '0));

    // R8: done follows the last column, bus idle in that cycle
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_col == LAST) |=> (ld_done && !arr_valid));

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !ld_done);

    // R8: done never appears without a last beat before it
    a_r8_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> ($past(arr_valid) && $past(arr_col) == LAST));

    // R4: the facing set does not move between beats of a load
    a_r4_set_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_col != LAST) |=> $stable(array_set));

    // R3: an idle swap flips the facing set
    a_r3_idle_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && !busy) |=> (array_set != $past(array_set)));
endmodule

bind pingpong_frame_buf fb_checker #(.COL_W($clog2(fb_pkg::FB_BEATS))) u_fb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .busy      (st_q.busy),
    .arr_valid (arr_valid),
    .arr_col   (arr_col),
    .ld_done   (ld_done),
    .array_set (array_set)
);

// File: tb/tb_pingpong_frame_buf.sv
`timescale 1ns/1ps
module tb_pingpong_frame_buf;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         swap_req;
    logic [6:0]   mem_addr;
    logic         mem_we;
    logic [63:0]  mem_wdata;
    logic [63:0]  mem_rdata;
    logic         ld_start;
    logic [9:0]   ld_base;
    logic         arr_valid;
    logic [2:0]   arr_col;
    logic [127:0] arr_data;
    logic         ld_done;
    logic         array_set;

    always #2.5 clk = ~clk;

    pingpong_frame_buf dut (
        .clk(clk), .rst_n(rst_n), .swap_req(swap_req),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_start(ld_start), .ld_base(ld_base),
        .arr_valid(arr_valid), .arr_col(arr_col), .arr_data(arr_data),
        .ld_done(ld_done), .array_set(array_set)
    );

    int           total = 0;
    int           bad = 0;
    bit           finished = 0;
    int           cur = 0;
    int           beats_seen = 0;
    bit           last_prev = 0;
    logic [63:0]  model [2][128];
    logic [127:0] q_data [$];
    logic [2:0]   q_col [$];
    logic [127:0] mon_d;
    logic [2:0]   mon_c;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [63:0] pword(input int seed, input int w);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[8*j +: 8] = 8'((w * 8 + j) * 7 + seed);
        return r;
    endfunction

    function automatic logic [127:0] beat_data(input int set, input int base, input int k);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) begin
            int a;
            a = (base + 16 * k + i) % 1024;
            r[8*i +: 8] = model[set][a / 8][8 * (a % 8) +: 8];
        end
        return r;
    endfunction

    // Driver side: push the expected beats of a load into the scoreboard.
    task automatic expect_load(input int base, input int set);
        for (int k = 0; k < 8; k++) begin
            q_data.push_back(beat_data(set, base, k));
            q_col.push_back(3'(k));
        end
    endtask

    task automatic fill_other(input int seed);
        for (int w = 0; w < 128; w++) begin
            mem_addr  = 7'(w);
            mem_wdata = pword(seed, w);
            mem_we    = 1'b1;
            tick();
            model[1 - cur][w] = pword(seed, w);
        end
        mem_we = 1'b0;
    endtask

    task automatic read_check(input int w, input string tag);
        mem_addr = 7'(w);
        mem_we   = 1'b0;
        tick();
        check(mem_rdata == model[1 - cur][w], tag, mem_rdata, model[1 - cur][w]);
    endtask

    task automatic do_load(input int base, input string tag);
        expect_load(base, cur);
        ld_base  = 10'(base);
        ld_start = 1'b1;
        tick();
        ld_start = 1'b0;
        repeat (11) tick();
        check(q_data.size() == 0, tag, q_data.size(), 0);
    endtask

    // Monitor: pops the scoreboard as beats appear, and checks done timing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_valid) begin
                beats_seen++;
                if (q_data.size() == 0) begin
                    check(1'b0, "R9 unexpected beat", arr_data, 0);
                end else begin
                    mon_d = q_data.pop_front();
                    mon_c = q_col.pop_front();
                    check(arr_data == mon_d, "R6 beat data", arr_data, mon_d);
                    check(arr_col == mon_c, "R5 column index", arr_col, mon_c);
                end
            end
            if (ld_done || last_prev) check(ld_done == last_prev, "R8 done timing", ld_done, last_prev);
            last_prev = arr_valid && (arr_col == 3'd7);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; swap_req = 1'b0; mem_addr = '0; mem_we = 1'b0;
        mem_wdata = '0; ld_start = 1'b0; ld_base = '0;
        repeat (3) tick();
        // R1: reset state
        check(arr_valid == 1'b0, "R1 arr_valid", arr_valid, 0);
        check(ld_done == 1'b0, "R1 ld_done", ld_done, 0);
        check(array_set == 1'b0, "R1 array_set", array_set, 0);
        check(mem_rdata == '0, "R1 mem_rdata", mem_rdata, 0);
        rst_n = 1'b1;
        tick();
        check(array_set == 1'b0 && arr_valid == 1'b0, "R1 after release", array_set, 0);

        // R2: memory side writes and reads the hidden set
        fill_other(11);
        read_check(0, "R2 read word 0");
        read_check(5, "R2 read word 5");
        read_check(127, "R2 read word 127");

        // R3: idle swap
        swap_req = 1'b1;
        tick();
        swap_req = 1'b0;
        cur = 1 - cur;
        check(array_set == 1'(cur), "R3 idle swap", array_set, cur);

        fill_other(50);
        read_check(3, "R2 read after swap");

        // R5/R6: aligned, unaligned and wrapping loads
        do_load(0, "R5 aligned load drained");
        do_load(13, "R6 unaligned load drained");
        do_load(1020, "R7 wrapping load drained");
        do_load(1017, "R7 odd-word wrapping load drained");

        // R9: start during a load is ignored
        beats_seen = 0;
        expect_load(40, cur);
        ld_base = 10'd40; ld_start = 1'b1;
        tick();
        ld_start = 1'b0;
        tick(); tick();
        ld_base = 10'd0; ld_start = 1'b1;
        tick();
        ld_start = 1'b0;
        repeat (10) tick();
        check(beats_seen == 8, "R9 beats per load", beats_seen, 8);
        check(q_data.size() == 0, "R9 queue drained", q_data.size(), 0);

        // R4/R11/R2: swaps and hidden-set writes during a load
        begin
            int old;
            old = cur;
            expect_load(200, cur);
            ld_base = 10'd200; ld_start = 1'b1;
            tick();                                   // E0
            ld_start = 1'b0;
            tick();                                   // E1
            swap_req = 1'b1;
            mem_addr = 7'd9; mem_wdata = 64'hDEAD_BEEF_0123_4567; mem_we = 1'b1;
            tick();                                   // E2
            model[1 - old][9] = 64'hDEAD_BEEF_0123_4567;
            swap_req = 1'b0; mem_we = 1'b0;
            tick();                                   // E3
            swap_req = 1'b1;
            tick();                                   // E4
            swap_req = 1'b0;
            check(array_set == 1'(old), "R4 set held mid-load", array_set, old);
            repeat (4) tick();                        // E8
            check(array_set == 1'(old), "R4 set held at last beat", array_set, old);
            tick();                                   // E9
            check(array_set == 1'(1 - old), "R4 deferred swap applied", array_set, 1 - old);
            tick();
            check(array_set == 1'(1 - old), "R11 single flip", array_set, 1 - old);
            cur = 1 - old;
            check(q_data.size() == 0, "R4 load unaffected", q_data.size(), 0);
        end
        // R2: word written during the load is now facing the array
        do_load(72, "R2 write during load landed");

        // R10: swap and start together
        expect_load(64, 1 - cur);
        swap_req = 1'b1; ld_start = 1'b1; ld_base = 10'd64;
        tick();
        swap_req = 1'b0; ld_start = 1'b0;
        cur = 1 - cur;
        check(array_set == 1'(cur), "R10 swap before load", array_set, cur);
        repeat (11) tick();
        check(q_data.size() == 0, "R10 load from new set", q_data.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule